// File: doc/BRIEF.md
# Ordering-Table Clear DMA Engine

This block is a single-purpose DMA channel that prepares an empty ordering table in main memory. Software programs a start address and an entry count, then writes a control word. When the control word carries the one accepted job pattern and the start address lies inside main memory, the engine walks downward from the start address. It writes one 32-bit entry per accepted memory beat. Every entry points to the entry just below it, and the lowest entry holds the end-of-list marker, so the table forms a chain of empty list heads that a consumer can later fill.

Any other control word with the go bit set finishes at once without touching memory. The same applies to a start address outside main memory. Every finish, normal or aborted, clears the go bit and the trigger bit of the control word and raises a one-cycle interrupt. The memory side is a write-only valid/ready port. The walk never descends to or past the floor of main memory.

Top module: `otc_clear_dma`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `irq` and `mem_wr_valid` are low and `ctrl_out` reads zero.
- R2: A write to the control register (`reg_sel` = 2) with bit 24 set, while idle, launches a job. Only the value 0x11000002 with a valid address performs memory writes. Any other launching value finishes with no memory write. A control write with bit 24 clear only stores the value and raises no interrupt.
- R3: Each entry except the final one, at byte address A, receives (A - 4) masked to 24 bits with the upper 8 data bits zero. The next entry is written at A - 4.
- R4: The final, lowest entry of a job receives 0x00FFFFFF, and no further write follows it.
- R5: The number of entries is the full 32-bit value of the count register (`reg_sel` = 1). A count of zero writes exactly one entry, the marker, at the start address.
- R6: Entries are written only above the memory floor MEM_LO, so a job writes at most (start - MEM_LO)/4 entries. A start equal to MEM_LO writes a single marker at MEM_LO.
- R7: A start address (`reg_sel` = 0) below MEM_LO or at or above MEM_HI aborts the job with no memory write.
- R8: When a job finishes, `irq` is high for exactly one cycle. In that cycle `busy` is low, every write of the job has completed, and bits 24 and 28 of `ctrl_out` read zero while its other bits keep the written value.
- R9: One entry is written in each cycle in which `mem_wr_ready` is high. While `mem_wr_valid` is high and `mem_wr_ready` is low, address and data hold.
- R10: The two low bits of the written start address are ignored.
- R11: Register writes while `busy` is high are ignored. A later launch uses the address and count stored before the job.
- R12: `busy` rises in the cycle after the launching write and stays high until the interrupt cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 start address, 1 entry count, 2 control, 3 none |
| reg_wdata | input | 32 | Register write data |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Byte address of the entry being written |
| mem_wr_data | output | 32 | Entry value |
| mem_wr_ready | input | 1 | Memory accepts the write this cycle |
| busy | output | 1 | Job in progress |
| irq | output | 1 | One-cycle completion interrupt |
| ctrl_out | output | 32 | Current control register value |

## Verification
On every cycle, the in-RTL assertions check four things. A stalled beat holds its address and data, and consecutive accepted entries step down by one word. Nothing is written after the marker or after a rejected launch. The interrupt never coincides with busy, and register writes during a job leave the stored address and count alone. Only the bench's scenarios can show the complete table contents and the entry count. These scenarios cover a zero count, a count wider than 16 bits, clipping at the memory floor, an unaligned start and out-of-range addresses. They also show that the control word ends with its two bits cleared and that a relaunch reuses the registers kept through a busy period.

// File: rtl/otc_pkg.sv
package otc_pkg;

    localparam logic [31:0] JOB_PATTERN = 32'h1100_0002;
    localparam logic [31:0] CTRL_CLEAR  = 32'h1100_0000;
    localparam int          GO_BIT      = 24;
    localparam logic [31:0] END_MARKER  = 32'h00FF_FFFF;
    localparam logic [31:0] PTR_MASK    = 32'h00FF_FFFF;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } walk_state_t;

    typedef struct packed {
        logic        last;
        logic [31:0] data;
    } wr_beat_t;

    // Entries to write: requested count clipped to the room above the floor,
    // never fewer than one (the marker).
    function automatic logic [31:0] entry_total(input logic [31:0] req,
                                                input logic [31:0] room);
        if (req == 32'd0 || room == 32'd0)
            return 32'd1;
        else if (req > room)
            return room;
        else
            return req;
    endfunction

endpackage

// File: rtl/otc_regs.sv
module otc_regs
    import otc_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              busy_i,
    input  logic              done_i,
    output logic [ADDR_W-3:0] start_word_o,
    output logic [31:0]       count_o,
    output logic [31:0]       ctrl_o,
    output logic              launch_o,
    output logic              irq_o
);
    localparam int AW = ADDR_W - 2;

    logic [AW-1:0] addr_q;
    logic [31:0]   cnt_q;
    logic [31:0]   ctrl_q;
    logic          irq_q;
    logic          wr_ok;

    assign wr_ok    = reg_wr_en && !busy_i;
    assign launch_o = wr_ok && (reg_sel == SEL_CTRL) && reg_wdata[GO_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= done_i;
            if (done_i) begin
                ctrl_q <= ctrl_q & ~CTRL_CLEAR;
            end else if (wr_ok) begin
                case (reg_sel)
                    SEL_ADDR:  addr_q <= reg_wdata[ADDR_W-1:2];
                    SEL_COUNT: cnt_q  <= reg_wdata;
                    SEL_CTRL:  ctrl_q <= reg_wdata;
                    default:   ;
                endcase
            end
        end
    end

    assign start_word_o = addr_q;
    assign count_o      = cnt_q;
    assign ctrl_o       = ctrl_q;
    assign irq_o        = irq_q;

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && reg_wr_en) |=> ($stable(addr_q) && $stable(cnt_q)));

endmodule

// File: rtl/otc_walker.sv
module otc_walker
    import otc_pkg::*;
#(
    parameter int          ADDR_W = 24,
    parameter int unsigned MEM_LO = 32'h0000_1000,
    parameter int unsigned MEM_HI = 32'h0020_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch_i,
    input  logic [31:0]       launch_ctrl_i,
    input  logic [ADDR_W-3:0] start_word_i,
    input  logic [31:0]       count_i,
    input  logic              mem_wr_ready,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              busy_o,
    output logic              done_o
);
    localparam int            AW   = ADDR_W - 2;
    localparam logic [AW-1:0] LO_W = AW'(MEM_LO >> 2);
    localparam logic [AW-1:0] HI_W = AW'(MEM_HI >> 2);

    walk_state_t   state_q;
    logic [AW-1:0] cur_q;
    logic [31:0]   rem_q;
    logic          addr_ok;
    logic          job_ok;
    logic [AW-1:0] room;
    logic [31:0]   total;
    wr_beat_t      beat;

    assign addr_ok = (start_word_i >= LO_W) && (start_word_i < HI_W);
    assign job_ok  = addr_ok && (launch_ctrl_i == JOB_PATTERN);
    assign room    = start_word_i - LO_W;
    assign total   = entry_total(count_i, 32'(room));

    always_comb begin
        beat.last = (rem_q == 32'd1);
        if (beat.last)
            beat.data = END_MARKER;
        else
            beat.data = 32'({cur_q - AW'(1), 2'b00}) & PTR_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            rem_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (launch_i) begin
                        if (job_ok) begin
                            cur_q   <= start_word_i;
                            rem_q   <= total;
                            state_q <= ST_RUN;
                        end else begin
                            state_q <= ST_FIN;
                        end
                    end
                end
                ST_RUN: begin
                    if (mem_wr_ready) begin
                        if (beat.last) begin
                            state_q <= ST_FIN;
                        end else begin
                            cur_q <= cur_q - AW'(1);
                            rem_q <= rem_q - 32'd1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_wr_valid = (state_q == ST_RUN);
    assign mem_wr_addr  = {cur_q, 2'b00};
    assign mem_wr_data  = beat.data;
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = (state_q == ST_FIN);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && mem_wr_ready && mem_wr_data != END_MARKER) |=>
            (mem_wr_valid && mem_wr_addr == $past(mem_wr_addr) - ADDR_W'(4)));

    // R4
    marker_last_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && mem_wr_ready && mem_wr_data == END_MARKER) |=> !mem_wr_valid);

    // R2
    bad_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (launch_i && launch_ctrl_i != JOB_PATTERN) |=> (!mem_wr_valid && busy_o));

    // R7
    bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (launch_i && !addr_ok) |=> !mem_wr_valid);

endmodule

// File: rtl/otc_clear_dma.sv
module otc_clear_dma
    import otc_pkg::*;
#(
    parameter int          ADDR_W = 24,
    parameter int unsigned MEM_LO = 32'h0000_1000,
    parameter int unsigned MEM_HI = 32'h0020_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    input  logic              mem_wr_ready,
    output logic              busy,
    output logic              irq,
    output logic [31:0]       ctrl_out
);
    logic [ADDR_W-3:0] start_word;
    logic [31:0]       count;
    logic              launch;
    logic              done;

    otc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .busy_i      (busy),
        .done_i      (done),
        .start_word_o(start_word),
        .count_o     (count),
        .ctrl_o      (ctrl_out),
        .launch_o    (launch),
        .irq_o       (irq)
    );

    otc_walker #(.ADDR_W(ADDR_W), .MEM_LO(MEM_LO), .MEM_HI(MEM_HI)) u_walker (
        .clk          (clk),
        .rst          (rst),
        .launch_i     (launch),
        .launch_ctrl_i(reg_wdata),
        .start_word_i (start_word),
        .count_i      (count),
        .mem_wr_ready (mem_wr_ready),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .busy_o       (busy),
        .done_o       (done)
    );

    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!busy && ctrl_out[24] == 1'b0 && ctrl_out[28] == 1'b0));

    // R12
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(launch));

endmodule

// File: tb/sim_otc_clear_dma.sv
`timescale 1ns/1ps
module sim_otc_clear_dma;
    localparam int          ADDR_W = 24;
    localparam int unsigned MEM_LO = 32'h0000_1000;
    localparam int unsigned MEM_HI = 32'h0020_0000;
    localparam logic [31:0] PAT    = 32'h1100_0002;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr_en = 1'b0;
    logic [1:0]        reg_sel = 2'd3;
    logic [31:0]       reg_wdata = '0;
    logic              mem_wr_valid;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [31:0]       mem_wr_data;
    logic              mem_wr_ready = 1'b1;
    logic              busy;
    logic              irq;
    logic [31:0]       ctrl_out;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    bit prev_irq = 0;
    bit stall_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] exp_addr_q[$];
    logic [31:0] exp_data_q[$];

    otc_clear_dma #(.ADDR_W(ADDR_W), .MEM_LO(MEM_LO), .MEM_HI(MEM_HI)) u0 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready), .busy(busy),
        .irq(irq), .ctrl_out(ctrl_out)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model: expected table for one launch.
    task automatic model_job(input logic [31:0] addr, input logic [31:0] cnt,
                             input logic [31:0] ctrl);
        logic [31:0] a;
        logic [31:0] room;
        logic [31:0] n;
        a = addr & 32'h00FF_FFFC;
        if (ctrl != PAT) return;
        if (a < MEM_LO || a >= MEM_HI) return;
        room = (a - MEM_LO) / 4;
        if (cnt == 0 || room == 0) n = 1;
        else if (cnt > room) n = room;
        else n = cnt;
        for (int i = 0; i < int'(n); i++) begin
            logic [31:0] ea;
            ea = a - 32'(4 * i);
            exp_addr_q.push_back(ea);
            exp_data_q.push_back((i == int'(n) - 1) ? 32'h00FF_FFFF
                                                     : ((ea - 4) & 32'h00FF_FFFF));
        end
    endtask

    // Per-cycle comparison against the model.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (mem_wr_valid && mem_wr_ready) begin
                    if (exp_addr_q.size() == 0) begin
                        check(0, "R2", "unexpected memory write", 32'(mem_wr_addr), 32'h0);
                    end else begin
                        logic [31:0] ea;
                        logic [31:0] ed;
                        ea = exp_addr_q.pop_front();
                        ed = exp_data_q.pop_front();
                        check(32'(mem_wr_addr) == ea, "R3", "entry address", 32'(mem_wr_addr), ea);
                        if (ed == 32'h00FF_FFFF)
                            check(mem_wr_data == ed, "R4", "marker value", mem_wr_data, ed);
                        else
                            check(mem_wr_data == ed, "R3", "link value", mem_wr_data, ed);
                    end
                end
                if (irq) begin
                    irq_seen++;
                    check(!prev_irq, "R8", "irq wider than one cycle", 32'(prev_irq), 32'h0);
                    check(!busy, "R8", "busy during irq", 32'(busy), 32'h0);
                    check(exp_addr_q.size() == 0, "R8", "writes left at irq",
                          32'(exp_addr_q.size()), 32'h0);
                end
                prev_irq = irq;
            end
        end
    end

    // Ready pattern, changed just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_wr_ready = stall_mode ? (lfsr[0] | lfsr[1]) : 1'b1;
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_sel   = 2'd3;
    endtask

    task automatic wait_irq(input int base, input string req);
        int n;
        n = 0;
        while (irq_seen == base && n < 100000) begin
            @(negedge clk);
            n++;
        end
        check(irq_seen == base + 1, req, "completion interrupt count",
              32'(irq_seen), 32'(base + 1));
    endtask

    task automatic run_job(input string req, input logic [31:0] addr,
                           input logic [31:0] cnt, input logic [31:0] ctrl);
        int base;
        reg_write(2'd0, addr);
        reg_write(2'd1, cnt);
        base = irq_seen;
        model_job(addr, cnt, ctrl);
        reg_write(2'd2, ctrl);
        // R12: busy one cycle after the launching edge
        check(busy, "R12", "busy after launch", 32'(busy), 32'h1);
        wait_irq(base, req);
        @(negedge clk);
        check(!busy, "R12", "busy after irq", 32'(busy), 32'h0);
        check(ctrl_out == (ctrl & ~32'h1100_0000), "R8", "control after finish",
              ctrl_out, ctrl & ~32'h1100_0000);
        check(exp_addr_q.size() == 0, req, "entries missing", 32'(exp_addr_q.size()), 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(!busy && !irq && !mem_wr_valid, "R1", "outputs in reset",
              {29'h0, busy, irq, mem_wr_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !irq && !mem_wr_valid, "R1", "outputs after reset",
              {29'h0, busy, irq, mem_wr_valid}, 32'h0);
        check(ctrl_out == 32'h0, "R1", "control after reset", ctrl_out, 32'h0);

        // R3 R4 R9: plain five-entry table under stalls
        stall_mode = 1;
        run_job("R3", 32'h0000_1040, 32'd5, PAT);
        // R5: zero count writes only the marker
        run_job("R5", 32'h0000_1080, 32'd0, PAT);
        // R6: clipped at the memory floor
        run_job("R6", 32'h0000_1010, 32'd10, PAT);
        // R6: start equal to floor
        run_job("R6", MEM_LO, 32'd3, PAT);
        // R10: unaligned start
        run_job("R10", 32'h0000_1043, 32'd2, PAT);
        // R2: other patterns with go bit finish without writes
        run_job("R2", 32'h0000_1040, 32'd4, 32'h0100_0002);
        run_job("R2", 32'h0000_1040, 32'd4, 32'h1100_0401);
        // R7: addresses outside memory
        run_job("R7", 32'h0030_0000, 32'd4, PAT);
        run_job("R7", 32'h0000_0800, 32'd4, PAT);

        // R2: control write without go bit only stores
        base = irq_seen;
        reg_write(2'd2, 32'h1000_0002);
        repeat (6) @(negedge clk);
        check(irq_seen == base && !busy, "R2", "no launch without go bit",
              32'(irq_seen - base), 32'h0);
        check(ctrl_out == 32'h1000_0002, "R2", "stored control", ctrl_out, 32'h1000_0002);

        // R11: writes during busy are ignored
        reg_write(2'd0, 32'h0000_1200);
        reg_write(2'd1, 32'd20);
        base = irq_seen;
        model_job(32'h0000_1200, 32'd20, PAT);
        reg_write(2'd2, PAT);
        reg_write(2'd0, 32'h0000_1800);
        reg_write(2'd1, 32'd2);
        reg_write(2'd2, 32'h0100_0000);
        wait_irq(base, "R11");
        @(negedge clk);
        check(ctrl_out == 32'h0000_0002, "R11", "control kept through busy",
              ctrl_out, 32'h0000_0002);
        base = irq_seen;
        model_job(32'h0000_1200, 32'd20, PAT);
        reg_write(2'd2, PAT);
        wait_irq(base, "R11");
        @(negedge clk);
        check(exp_addr_q.size() == 0, "R11", "relaunch used stored registers",
              32'(exp_addr_q.size()), 32'h0);

        // R5 R9: count above 16 bits at full rate
        stall_mode = 0;
        run_job("R5", 32'h001F_FFFC, 32'h0001_0002, PAT);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule